// File: doc/BRIEF.md
# SDR SDRAM Burst and Byte-Mask Data Path

This block is the column-side engine of a behavioural single-data-rate SDRAM device model. It holds the programmable mode word, which sets the read latency, the number of beats per burst, the wrap order and an option that forces writes to a single beat. On each read or write command it produces the column for every beat of the burst. It moves 32-bit words between a small bank-by-column storage array and the data bus. It also applies the per-byte data masks, which act at once on writes and two clocks late on reads.

A decoded command arrives on `cmd_i` together with the bank and starting column. Write data for beat 0 travels with the write command, and each later beat follows one clock after the one before. Read data leaves on `dq_o`, with a per-byte output enable that stands in for the high-impedance state of a real pin. Row activation, precharge and refresh belong to other blocks. The `all_idle_i` input reports whether every bank is precharged.

Top module: `sdr_burst_path`

## Requirements
- R1: `cmd_i` codes are 0 none, 1 read, 2 write, 3 mode load and 4 burst stop, and any other code acts as none. A mode load copies `mode_i` only when `all_idle_i` is high, and is ignored otherwise. The mode word has the length code in bits 2:0, interleaved order in bit 3, the latency code in bits 6:4 and single-beat writes in bit 9. Reset leaves a length of 1, sequential order, latency 2 and burst writes.
- R2: A latency code of 3 selects 3 clocks, and any other code selects 2. Read beat k of a command sampled at edge T is on `dq_o` at edge T+latency+k, driven after edge T+latency+k-1.
- R3: Length codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats, 111 gives a full page, and any other code gives 1 beat. Write beat k stores the `dq_i` value sampled at edge T+k.
- R4: Sequential order steps upward from the start column and wraps inside the aligned block of burst-length columns.
- R5: Interleaved order gives beat k the column start XOR k. A full-page burst always uses sequential order.
- R6: A full-page burst steps through all 256 columns, wraps from 255 to 0, and runs until a burst stop or a new command ends it.
- R7: A burst stop at edge S lets no beat start at S or later. Write data at S is not stored, and read beats that started before S still come out.
- R8: A read or write command that arrives during a burst replaces that burst at its own edge.
- R9: On a write, `dqm_i` bit b high at an edge keeps byte b (bits 8b+7:8b) of that same edge's beat out of the array.
- R10: On a read, `dqm_i` bit b high at edge E clears `dq_oe_o[b]` and zeroes byte b of `dq_o` at edge E+2, whatever the latency.
- R11: With single-beat writes selected, a write stores only beat 0, while reads keep the programmed length.
- R12: `dq_oe_o` is zero after reset and in every cycle that carries no read beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Decoded command code (see R1) |
| all_idle_i | input | 1 | High when every bank is precharged |
| mode_i | input | 10 | Mode word taken by a mode load |
| bank_i | input | 2 | Bank of a read or write command |
| col_i | input | 8 | Starting column of a read or write command |
| dq_i | input | 32 | Write data |
| dqm_i | input | 4 | Per-byte data mask |
| dq_o | output | 32 | Read data; masked bytes read as zero |
| dq_oe_o | output | 4 | Per-byte output enable |

## Verification
The bench goes after the column order at the edges of a burst. It checks a sequential start near the top of an aligned block, an interleaved start in mid-block and a full-page start at column 250 that must wrap to 0. A wrong order shows up as read-back words from neighbouring columns. It times the read mask against both latencies, because a design that ties the mask to the latency would blank the wrong beat at latency 3. It also checks a burst stop that meets write data, a mode load while banks are busy, a reserved length code and a read cut short by a second read. A design that handled any of these wrongly would store stray words, switch latency or keep driving the bus after the burst should have ended.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    localparam int MODE_W = 10;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_MRS   = 3'd3,
        CMD_STOP  = 3'd4
    } sdr_cmd_e;

    typedef struct packed {
        logic [2:0] len_code;
        logic       ilv;
        logic [2:0] lat_code;
        logic       single_wr;
    } sdr_mode_t;

    localparam sdr_mode_t MODE_RESET = '{len_code: 3'b000, ilv: 1'b0,
                                         lat_code: 3'b010, single_wr: 1'b0};

    function automatic sdr_cmd_e decode_cmd(input logic [2:0] raw);
        case (raw)
            3'd1:    return CMD_READ;
            3'd2:    return CMD_WRITE;
            3'd3:    return CMD_MRS;
            3'd4:    return CMD_STOP;
            default: return CMD_NOP;
        endcase
    endfunction

    function automatic sdr_mode_t pack_mode(input logic [MODE_W-1:0] op);
        sdr_mode_t m;
        m.len_code  = op[2:0];
        m.ilv       = op[3];
        m.lat_code  = op[6:4];
        m.single_wr = op[9];
        return m;
    endfunction

    function automatic int lat_clocks(input logic [2:0] code);
        return (code == 3'b011) ? 3 : 2;
    endfunction

    function automatic logic is_page(input logic [2:0] code);
        return code == 3'b111;
    endfunction

    function automatic int len_log2(input logic [2:0] code);
        case (code)
            3'b001:  return 1;
            3'b010:  return 2;
            3'b011:  return 3;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] op_i,
    output sdr_mode_t         mode_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= MODE_RESET;
        end else if (load) begin
            mode_o <= pack_mode(op_i);
        end
    end

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_burst_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  sdr_cmd_e          cmd,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [2:0]        len_code,
    input  logic              ilv_i,
    input  logic              single_wr_i,
    output logic              beat_vld,
    output logic              beat_wr,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col
);

    typedef struct packed {
        logic              active;
        logic              wr;
        logic              endless;
        logic              ilv;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  start;
        logic [COL_W-1:0]  idx;
        logic [COL_W-1:0]  mask;
    } burst_t;

    burst_t             st;
    logic               start_cmd;
    logic               is_wr;
    logic               page;
    logic [COL_W-1:0]   new_mask;
    logic [COL_W-1:0]   seq_col;
    logic [COL_W-1:0]   ilv_col;

    always_comb begin
        start_cmd = (cmd == CMD_READ) || (cmd == CMD_WRITE);
        is_wr     = (cmd == CMD_WRITE);
        page      = is_page(len_code);
        if (is_wr && single_wr_i) begin
            new_mask = '0;
        end else if (page) begin
            new_mask = '1;
        end else begin
            new_mask = COL_W'((1 << len_log2(len_code)) - 1);
        end
    end

    // column of the beat carried by the stored burst state
    always_comb begin
        seq_col = (st.start & ~st.mask) | ((st.start + st.idx) & st.mask);
        ilv_col = st.start ^ (st.idx & st.mask);
    end

    always_comb begin
        beat_vld  = 1'b0;
        beat_wr   = st.wr;
        beat_bank = st.bank;
        beat_col  = st.ilv ? ilv_col : seq_col;
        if (start_cmd) begin
            beat_vld  = 1'b1;
            beat_wr   = is_wr;
            beat_bank = bank_i;
            beat_col  = col_i;
        end else if (st.active && (cmd != CMD_STOP)) begin
            beat_vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (start_cmd) begin
            st.active  <= (new_mask != '0);
            st.wr      <= is_wr;
            st.endless <= page && !(is_wr && single_wr_i);
            st.ilv     <= ilv_i && !page;
            st.bank    <= bank_i;
            st.start   <= col_i;
            st.idx     <= COL_W'(1);
            st.mask    <= new_mask;
        end else if (cmd == CMD_STOP) begin
            st.active <= 1'b0;
        end else if (st.active) begin
            st.idx <= st.idx + 1'b1;
            if (!st.endless && (st.idx == st.mask)) begin
                st.active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdr_col_array.sv
module sdr_col_array #(
    parameter int BANK_W   = 2,
    parameter int COL_W    = 8,
    parameter int DQ_BYTES = 4
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [BANK_W+COL_W-1:0]    addr,
    input  logic [DQ_BYTES*8-1:0]      wdata,
    input  logic [DQ_BYTES-1:0]        byte_en,
    output logic [DQ_BYTES*8-1:0]      rdata
);

    localparam int DEPTH = 1 << (BANK_W + COL_W);
    localparam int DQ_W  = DQ_BYTES * 8;

    logic [DQ_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < DQ_BYTES; b++) begin
                if (byte_en[b]) begin
                    mem[addr][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe #(
    parameter int DQ_BYTES = 4,
    parameter int MAX_CL   = 3,
    localparam int DQ_W    = DQ_BYTES * 8,
    localparam int LAT_W   = $clog2(MAX_CL)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_vld,
    input  logic [DQ_W-1:0]     rd_data,
    input  logic [LAT_W-1:0]    lat_sel,
    input  logic [DQ_BYTES-1:0] dqm_i,
    output logic [DQ_W-1:0]     dq_o,
    output logic [DQ_BYTES-1:0] dq_oe_o
);

    logic [MAX_CL-1:0]   vld_q;
    logic [DQ_W-1:0]     dat_q [MAX_CL];
    logic [DQ_BYTES-1:0] dqm_q1;
    logic [DQ_BYTES-1:0] dqm_q2;
    logic                out_vld;
    logic [DQ_W-1:0]     out_dat;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            dqm_q1 <= '0;
            dqm_q2 <= '0;
        end else begin
            vld_q  <= {vld_q[MAX_CL-2:0], rd_vld};
            dqm_q1 <= dqm_i;
            dqm_q2 <= dqm_q1;
        end
    end

    for (genvar i = 0; i < MAX_CL; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) dat_q[i] <= rd_data;
        end else begin : g_tail
            always_ff @(posedge clk) dat_q[i] <= dat_q[i-1];
        end
    end

    always_comb begin
        out_vld = vld_q[lat_sel];
        out_dat = dat_q[lat_sel];
    end

    for (genvar b = 0; b < DQ_BYTES; b++) begin : g_byte
        assign dq_oe_o[b]        = out_vld & ~dqm_q2[b];
        assign dq_o[8*b +: 8]    = out_dat[8*b +: 8] & {8{dq_oe_o[b]}};
    end

endmodule

// File: rtl/sdr_burst_path.sv
module sdr_burst_path
    import sdr_burst_pkg::*;
#(
    parameter int BANK_W   = 2,
    parameter int COL_W    = 8,
    parameter int DQ_BYTES = 4,
    parameter int MAX_CL   = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            cmd_i,
    input  logic                  all_idle_i,
    input  logic [MODE_W-1:0]     mode_i,
    input  logic [BANK_W-1:0]     bank_i,
    input  logic [COL_W-1:0]      col_i,
    input  logic [DQ_BYTES*8-1:0] dq_i,
    input  logic [DQ_BYTES-1:0]   dqm_i,
    output logic [DQ_BYTES*8-1:0] dq_o,
    output logic [DQ_BYTES-1:0]   dq_oe_o
);

    localparam int DQ_W  = DQ_BYTES * 8;
    localparam int LAT_W = $clog2(MAX_CL);

    sdr_cmd_e          cmd;
    sdr_mode_t         mode_q;
    logic              beat_vld;
    logic              beat_wr;
    logic [BANK_W-1:0] beat_bank;
    logic [COL_W-1:0]  beat_col;
    logic [DQ_W-1:0]   rd_word;
    logic [LAT_W-1:0]  lat_sel;

    assign cmd     = decode_cmd(cmd_i);
    assign lat_sel = LAT_W'(lat_clocks(mode_q.lat_code) - 1);

    sdr_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .load   ((cmd == CMD_MRS) && all_idle_i),
        .op_i   (mode_i),
        .mode_o (mode_q)
    );

    sdr_burst_seq #(.BANK_W(BANK_W), .COL_W(COL_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .bank_i      (bank_i),
        .col_i       (col_i),
        .len_code    (mode_q.len_code),
        .ilv_i       (mode_q.ilv),
        .single_wr_i (mode_q.single_wr),
        .beat_vld    (beat_vld),
        .beat_wr     (beat_wr),
        .beat_bank   (beat_bank),
        .beat_col    (beat_col)
    );

    sdr_col_array #(.BANK_W(BANK_W), .COL_W(COL_W), .DQ_BYTES(DQ_BYTES)) u_array (
        .clk     (clk),
        .we      (beat_vld && beat_wr),
        .addr    ({beat_bank, beat_col}),
        .wdata   (dq_i),
        .byte_en (~dqm_i),
        .rdata   (rd_word)
    );

    sdr_read_pipe #(.DQ_BYTES(DQ_BYTES), .MAX_CL(MAX_CL)) u_rpipe (
        .clk     (clk),
        .rst     (rst),
        .rd_vld  (beat_vld && !beat_wr),
        .rd_data (rd_word),
        .lat_sel (lat_sel),
        .dqm_i   (dqm_i),
        .dq_o    (dq_o),
        .dq_oe_o (dq_oe_o)
    );

endmodule

// File: rtl/sdr_burst_path_chk.sv
module sdr_burst_path_chk
    import sdr_burst_pkg::*;
#(
    parameter int DQ_BYTES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          cmd_i,
    input logic                all_idle_i,
    input logic [DQ_BYTES-1:0] dqm_i,
    input logic [DQ_BYTES-1:0] dq_oe_o,
    input sdr_mode_t           mode_q,
    input logic                beat_vld
);

    logic [1:0] since_rst;
    sdr_cmd_e   c;

    assign c = decode_cmd(cmd_i);

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_MRS && !all_idle_i) |=> $stable(mode_q)); // R1

    AST_READ_MASK_TWO: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> ((dq_oe_o & $past(dqm_i, 2)) == '0)); // R10

    AST_STOP_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_STOP) |=> (!beat_vld || c == CMD_READ || c == CMD_WRITE)); // R7

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_WRITE && mode_q.single_wr) |=> (!beat_vld || c == CMD_READ || c == CMD_WRITE)); // R11

endmodule

bind sdr_burst_path sdr_burst_path_chk #(.DQ_BYTES(DQ_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd_i),
    .all_idle_i (all_idle_i),
    .dqm_i      (dqm_i),
    .dq_oe_o    (dq_oe_o),
    .mode_q     (mode_q),
    .beat_vld   (beat_vld)
);

// File: tb/sdr_burst_path_test.sv
module sdr_burst_path_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd = 3'd0;
    logic        all_idle = 1'b1;
    logic [9:0]  mode = 10'd0;
    logic [1:0]  bank = 2'd0;
    logic [7:0]  col = 8'd0;
    logic [31:0] dq_in = 32'd0;
    logic [3:0]  dqm = 4'd0;
    logic [31:0] dq_out;
    logic [3:0]  dq_oe;

    always #4 clk = ~clk;

    sdr_burst_path uut (
        .clk(clk), .rst(rst), .cmd_i(cmd), .all_idle_i(all_idle), .mode_i(mode),
        .bank_i(bank), .col_i(col), .dq_i(dq_in), .dqm_i(dqm),
        .dq_o(dq_out), .dq_oe_o(dq_oe)
    );

    typedef struct {
        int          at;
        logic [3:0]  oe;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t        q[$];
    logic [31:0] model [1024];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] bmask(input logic [3:0] oe);
        logic [31:0] m;
        for (int y = 0; y < 4; y++) m[8*y +: 8] = {8{oe[y]}};
        return m;
    endfunction

    function automatic int order(input int s, input int k, input int len, input bit ilv);
        if (len == 256) return (s + k) % 256;
        if (ilv) return s ^ k;
        return (s - s % len) + ((s % len + k) % len);
    endfunction

    // scoreboard monitor: compares at the falling edge
    exp_t e;
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].at == cyc) begin
                e = q.pop_front();
                n_chk++;
                if (dq_oe !== e.oe || (dq_out & bmask(dq_oe)) !== e.data) begin
                    n_fail++;
                    $display("FAIL %s cyc %0d: oe=%h dq=%h expected oe=%h dq=%h",
                             e.req, cyc, dq_oe, dq_out, e.oe, e.data);
                end
            end else if (dq_oe !== 4'h0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R12 cyc %0d: oe=%h dq=%h expected oe=0 dq=0", cyc, dq_oe, dq_out);
            end
        end
    end

    task automatic step(input logic [2:0] c, input int b, input int s,
                        input logic [31:0] d, input logic [3:0] m);
        cmd = c; bank = 2'(b); col = 8'(s); dq_in = d; dqm = m;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(3'd0, 0, 0, 32'd0, 4'd0);
    endtask

    task automatic set_mode(input logic [9:0] bits, input logic idle_flag);
        mode = bits; all_idle = idle_flag;
        step(3'd3, 0, 0, 32'd0, 4'd0);
        all_idle = 1'b1;
        idle(2);
    endtask

    task automatic wr(input int b, input int s, input int len, input bit ilv,
                      input int steps, input int nb, input int seed, input logic [3:0] m0);
        for (int j = 0; j < steps; j++) begin
            logic [31:0] d;
            logic [3:0]  m;
            d = 32'h9E3779B1 * 32'(seed * 131 + j + 7);
            m = (j == 0) ? m0 : 4'h0;
            if (j < nb) begin
                int c;
                c = order(s, j, len, ilv);
                for (int y = 0; y < 4; y++)
                    if (!m[y]) model[b*256 + c][8*y +: 8] = d[8*y +: 8];
            end
            step((j == 0) ? 3'd2 : 3'd0, b, s, d, m);
        end
    endtask

    // masks: nibble j is the dqm driven in step j
    task automatic rd(input int b, input int s, input int len, input bit ilv, input int cl,
                      input int steps, input int nb, input logic [31:0] masks, input string req);
        int e0;
        e0 = cyc + 1;
        for (int k = 0; k < nb; k++) begin
            exp_t it;
            int c;
            int j;
            logic [3:0] m;
            c = order(s, k, len, ilv);
            j = k + cl - 2;
            m = (j < steps && j < 8) ? masks[4*j +: 4] : 4'h0;
            it.at = e0 + cl - 1 + k;
            it.oe = ~m;
            it.data = model[b*256 + c] & bmask(~m);
            it.req = req;
            q.push_back(it);
        end
        for (int j = 0; j < steps; j++)
            step((j == 0) ? 3'd1 : 3'd0, b, s, 32'd0, (j < 8) ? masks[4*j +: 4] : 4'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_chk++;
        if (dq_oe !== 4'h0) begin
            n_fail++;
            $display("FAIL R12 reset: oe=%h expected 0", dq_oe);
        end
        // R1 reset mode: one beat, latency 2
        wr(1, 3, 1, 0, 1, 1, 11, 4'h0);
        rd(1, 3, 1, 0, 2, 3, 1, 32'h0, "R1");
        idle(3);
        // R6 full-page write of bank 0, stopped; R7 stop edge data is dropped
        set_mode(10'h027, 1'b1);
        wr(0, 0, 256, 0, 256, 256, 1, 4'h0);
        step(3'd4, 0, 0, 32'hDEADBEEF, 4'h0);
        idle(2);
        rd(0, 250, 256, 0, 2, 10, 10, 32'h0, "R6");
        step(3'd4, 0, 0, 32'd0, 4'd0);   // R7: no beats after this
        idle(4);
        // R4 sequential wrap, R2 latency 3
        set_mode(10'h032, 1'b1);
        rd(0, 6, 4, 0, 3, 4, 4, 32'h0, "R4");
        idle(4);
        // R5 interleaved order; R9 write mask
        set_mode(10'h02B, 1'b1);
        rd(0, 5, 8, 1, 2, 8, 8, 32'h0, "R5");
        idle(3);
        wr(1, 8, 8, 1, 8, 8, 21, 4'h0);
        wr(1, 13, 8, 1, 8, 8, 22, 4'b0101);
        rd(1, 13, 8, 1, 2, 8, 8, 32'h0, "R9");
        idle(3);
        // R10 read mask at latency 2
        rd(0, 16, 8, 1, 2, 8, 8, 32'h5000_F0A1, "R10");
        idle(3);
        // R1 mode load while busy is ignored: still interleaved, latency 2
        set_mode(10'h03A, 1'b0);
        rd(0, 2, 8, 1, 2, 8, 8, 32'h0, "R1");
        idle(3);
        // R11 single-beat writes, reads keep 4 beats
        set_mode(10'h022, 1'b1);
        wr(1, 40, 4, 0, 4, 4, 31, 4'h0);
        wr(1, 60, 4, 0, 4, 4, 33, 4'h0);
        set_mode(10'h222, 1'b1);
        wr(1, 40, 4, 0, 4, 1, 32, 4'h0);
        rd(1, 40, 4, 0, 2, 4, 4, 32'h0, "R11");
        idle(3);
        // R8 write cut by write, read cut by read
        set_mode(10'h022, 1'b1);
        wr(1, 60, 4, 0, 2, 2, 34, 4'h0);
        wr(1, 70, 4, 0, 4, 4, 35, 4'h0);
        rd(1, 60, 4, 0, 2, 4, 4, 32'h0, "R8");
        idle(3);
        rd(0, 0, 4, 0, 2, 1, 1, 32'h0, "R8");
        rd(0, 100, 4, 0, 2, 4, 4, 32'h0, "R8");
        idle(3);
        // R10 read mask at latency 3
        set_mode(10'h033, 1'b1);
        rd(0, 20, 8, 0, 3, 8, 8, 32'h0003_0F10, "R10");
        idle(4);
        // R3 two-beat length and reserved length code gives one beat
        set_mode(10'h021, 1'b1);
        rd(0, 9, 2, 0, 2, 2, 2, 32'h0, "R3");
        idle(3);
        set_mode(10'h024, 1'b1);
        rd(0, 7, 1, 0, 2, 4, 1, 32'h0, "R3");
        idle(4);
        // R7 column 0 kept its full-page value
        set_mode(10'h020, 1'b1);
        rd(0, 0, 1, 0, 2, 1, 1, 32'h0, "R7");
        idle(6);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule